// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This block decides, once per cycle, which address the fetch stage requests next in a stream of fixed 32-bit instructions. Each cycle it is given the address of the instruction being resolved, a 4-bit control code, two register operands, a 16-bit signed displacement, a 26-bit jump index and a register-held jump address. From these it raises a taken flag and a link-write request for register 31. It also produces the next fetch address.

Control transfers use one delay slot. A taken branch or jump does not change the next address at once. The instruction right after it is fetched and executed first, and only then does the held target become the next address. Conditional branches test either two registers for equality or inequality, or one register against zero as a signed value. No condition flags are involved.

The design is a two-state machine. The states are `ST_SEQ` (sequential fetch) and `ST_SLOT` (delay slot in progress, target held). The transitions are:
- `ST_SEQ -> ST_SLOT` when a transfer is taken.
- `ST_SEQ -> ST_SEQ` otherwise.
- `ST_SLOT -> ST_SEQ` always, after one cycle.

Top module: `npc_unit`

## Requirements
- R1: When reset is released, the unit is in sequential fetch. `npc_o` equals `pc_i + 4` and nothing is held.
- R2: Codes 0 and 12 to 15 are not control transfers. With these codes `taken_o` is 0, `link_we_o` is 0 and `npc_o` equals `pc_i + 4`.
- R3: Code 1 (equal) is taken when `rs_val_i == rt_val_i`. Code 2 (not-equal) is taken when the two registers differ.
- R4: The zero-compare codes test `rs_val_i` as a signed value. Code 3 is taken when the value is <=0, code 4 when >0, code 5 when <0 and code 6 when >=0. Codes 7 and 8 test <0 and >=0.
- R5: The target of a conditional branch is `pc_i + 4 + (sign-extended offset_i << 2)`. During the branch's own cycle, `npc_o` stays at `pc_i + 4`.
- R6: Codes 9 (jump) and 10 (jump-and-link) are always taken. Their target is bits [31:28] of `pc_i + 4`, followed by `jidx_i`, followed by two zero bits.
- R7: Code 11 (jump-register) is always taken, and its target is `jreg_i` unchanged.
- R8: Codes 7, 8 and 10 raise `link_we_o` whether or not the transfer is taken. With it they present `link_data_o = pc_i + 4` and `link_reg_o = 31`. No other code raises `link_we_o`.
- R9: In the cycle after a taken transfer (the delay slot), `npc_o` is the held target, whatever `pc_i` is. A control code in the slot is ignored, so `taken_o` and `link_we_o` are both 0.
- R10: In the cycle after a delay slot, sequential fetch resumes and the unit decodes the code presented in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | 32 | Address of the instruction being resolved |
| op_i | input | 4 | Control code (encoding in R2 to R8) |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand |
| offset_i | input | 16 | Signed branch displacement in instructions |
| jidx_i | input | 26 | Jump index field |
| jreg_i | input | 32 | Register-held jump address |
| npc_o | output | 32 | Next fetch address |
| taken_o | output | 1 | Transfer taken this cycle |
| link_we_o | output | 1 | Request to write the link register |
| link_reg_o | output | 5 | Link register number |
| link_data_o | output | 32 | Link value |

## Verification
The taken flag, the link request and the sequential next address are combinational, so they are due in the same cycle as the inputs. The redirected address is due exactly one clock edge after a taken transfer, and sequential fetch resumes one edge after that. The bench drives inputs just after the falling edge and samples all outputs one time step later. It advances its own model of the held target only at the rising edge, so each check compares against the value due in that exact cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_BEQ    = 4'd1,
        OP_BNE    = 4'd2,
        OP_BLEZ   = 4'd3,
        OP_BGTZ   = 4'd4,
        OP_BLTZ   = 4'd5,
        OP_BGEZ   = 4'd6,
        OP_BLTZAL = 4'd7,
        OP_BGEZAL = 4'd8,
        OP_J      = 4'd9,
        OP_JAL    = 4'd10,
        OP_JR     = 4'd11
    } ctl_op_e;

    typedef enum logic {
        ST_SEQ  = 1'b0,
        ST_SLOT = 1'b1
    } slot_state_e;

    typedef enum logic [1:0] {
        TK_REL    = 2'd0,
        TK_REGION = 2'd1,
        TK_REG    = 2'd2
    } tgt_kind_e;

    typedef struct packed {
        logic      is_ctl;
        logic      link;
        tgt_kind_e kind;
    } ctl_dec_t;

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [3:0]      op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output ctl_dec_t        dec_o,
    output logic            cond_o
);

    logic is_zero;
    logic is_neg;
    logic is_eq;

    assign is_zero = (a_i == '0);
    assign is_neg  = a_i[XLEN-1];
    assign is_eq   = (a_i == b_i);

    always_comb begin
        dec_o.is_ctl = 1'b0;
        dec_o.link   = 1'b0;
        dec_o.kind   = TK_REL;
        cond_o       = 1'b0;
        unique case (op_i)
            OP_BEQ:    begin dec_o.is_ctl = 1'b1; cond_o = is_eq; end
            OP_BNE:    begin dec_o.is_ctl = 1'b1; cond_o = !is_eq; end
            OP_BLEZ:   begin dec_o.is_ctl = 1'b1; cond_o = is_neg || is_zero; end
            OP_BGTZ:   begin dec_o.is_ctl = 1'b1; cond_o = !is_neg && !is_zero; end
            OP_BLTZ:   begin dec_o.is_ctl = 1'b1; cond_o = is_neg; end
            OP_BGEZ:   begin dec_o.is_ctl = 1'b1; cond_o = !is_neg; end
            OP_BLTZAL: begin dec_o.is_ctl = 1'b1; dec_o.link = 1'b1; cond_o = is_neg; end
            OP_BGEZAL: begin dec_o.is_ctl = 1'b1; dec_o.link = 1'b1; cond_o = !is_neg; end
            OP_J:      begin dec_o.is_ctl = 1'b1; dec_o.kind = TK_REGION; cond_o = 1'b1; end
            OP_JAL:    begin
                dec_o.is_ctl = 1'b1; dec_o.link = 1'b1;
                dec_o.kind = TK_REGION; cond_o = 1'b1;
            end
            OP_JR:     begin dec_o.is_ctl = 1'b1; dec_o.kind = TK_REG; cond_o = 1'b1; end
            default:   begin dec_o.is_ctl = 1'b0; cond_o = 1'b0; end
        endcase
    end

    always_comb begin
        assert (!(dec_o.link && !dec_o.is_ctl)); // R8
    end

endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int OFF_W      = 16,
    parameter int IDX_W      = 26,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic [IDX_W-1:0] jidx_i,
    input  logic [XLEN-1:0]  jreg_i,
    input  tgt_kind_e        kind_i,
    output logic [XLEN-1:0]  seq_o,
    output logic [XLEN-1:0]  tgt_o
);

    localparam int SHIFT    = $clog2(INSN_BYTES);
    localparam int REGION_W = XLEN - IDX_W - SHIFT;

    logic [XLEN-1:0] off_sx;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] region_tgt;

    assign seq_o   = pc_i + XLEN'(INSN_BYTES);
    assign off_sx  = {{(XLEN-OFF_W){offset_i[OFF_W-1]}}, offset_i};
    assign rel_tgt = seq_o + (off_sx << SHIFT);

    generate
        if (REGION_W > 0) begin : g_region
            assign region_tgt = {seq_o[XLEN-1 -: REGION_W], jidx_i, {SHIFT{1'b0}}};
        end else begin : g_flat
            logic [IDX_W+SHIFT-1:0] wide;
            assign wide       = {jidx_i, {SHIFT{1'b0}}};
            assign region_tgt = wide[XLEN-1:0];
        end
    endgenerate

    always_comb begin
        unique case (kind_i)
            TK_REGION: tgt_o = region_tgt;
            TK_REG:    tgt_o = jreg_i;
            default:   tgt_o = rel_tgt;
        endcase
    end

    always_comb begin
        if (kind_i == TK_REGION) assert (tgt_o[SHIFT-1:0] == '0); // R6
    end

endmodule

// File: rtl/npc_slot_fsm.sv
module npc_slot_fsm
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic [XLEN-1:0] tgt_i,
    output logic            slot_o,
    output logic [XLEN-1:0] held_o
);

    slot_state_e     state_q;
    logic [XLEN-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEQ;
        end else begin
            unique case (state_q)
                ST_SEQ:  state_q <= take_i ? ST_SLOT : ST_SEQ;
                ST_SLOT: state_q <= ST_SEQ;
                default: state_q <= ST_SEQ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (state_q == ST_SEQ && take_i) begin
            held_q <= tgt_i;
        end
    end

    always_comb begin
        slot_o = (state_q == ST_SLOT);
        held_o = held_q;
    end

    AST_SLOT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLOT) |=> (state_q == ST_SEQ)); // R10

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int OFF_W      = 16,
    parameter int IDX_W      = 26,
    parameter int INSN_BYTES = 4,
    parameter int RADDR_W    = 5,
    parameter int LINK_REG   = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [3:0]         op_i,
    input  logic [XLEN-1:0]    rs_val_i,
    input  logic [XLEN-1:0]    rt_val_i,
    input  logic [OFF_W-1:0]   offset_i,
    input  logic [IDX_W-1:0]   jidx_i,
    input  logic [XLEN-1:0]    jreg_i,
    output logic [XLEN-1:0]    npc_o,
    output logic               taken_o,
    output logic               link_we_o,
    output logic [RADDR_W-1:0] link_reg_o,
    output logic [XLEN-1:0]    link_data_o
);

    ctl_dec_t        dec;
    logic            cond_met;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] tgt;
    logic            in_slot;
    logic [XLEN-1:0] held_tgt;
    logic            take;

    npc_cond #(.XLEN(XLEN)) cond_i (
        .op_i   (op_i),
        .a_i    (rs_val_i),
        .b_i    (rt_val_i),
        .dec_o  (dec),
        .cond_o (cond_met)
    );

    npc_target #(
        .XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W), .INSN_BYTES(INSN_BYTES)
    ) target_i (
        .pc_i     (pc_i),
        .offset_i (offset_i),
        .jidx_i   (jidx_i),
        .jreg_i   (jreg_i),
        .kind_i   (dec.kind),
        .seq_o    (seq_pc),
        .tgt_o    (tgt)
    );

    assign take = dec.is_ctl && cond_met && !in_slot;

    npc_slot_fsm #(.XLEN(XLEN)) fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .tgt_i  (tgt),
        .slot_o (in_slot),
        .held_o (held_tgt)
    );

    always_comb begin
        taken_o     = take;
        link_we_o   = dec.link && !in_slot;
        link_reg_o  = RADDR_W'(LINK_REG);
        link_data_o = seq_pc;
        npc_o       = in_slot ? held_tgt : seq_pc;
    end

    AST_REDIRECT_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |=> (npc_o == $past(tgt))); // R9

    AST_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |=> (!taken_o && !link_we_o)); // R9

    AST_LINK_TARGET_REG: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_reg_o == RADDR_W'(LINK_REG) && link_data_o == pc_i + XLEN'(INSN_BYTES))); // R8

    AST_NONCTL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 || op_i > 4'd11) |-> (!taken_o && !link_we_o)); // R2

    AST_RESUME_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |=> ##1 (npc_o == pc_i + XLEN'(INSN_BYTES) || taken_o || $past(taken_o))); // R10

endmodule

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic [3:0]  op_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [31:0] rt_val_i = '0;
    logic [15:0] offset_i = '0;
    logic [25:0] jidx_i = '0;
    logic [31:0] jreg_i = '0;
    logic [31:0] npc_o;
    logic        taken_o;
    logic        link_we_o;
    logic [4:0]  link_reg_o;
    logic [31:0] link_data_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    bit          m_slot = 1'b0;
    logic [31:0] m_held = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .op_i(op_i),
        .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .offset_i(offset_i),
        .jidx_i(jidx_i), .jreg_i(jreg_i), .npc_o(npc_o), .taken_o(taken_o),
        .link_we_o(link_we_o), .link_reg_o(link_reg_o), .link_data_o(link_data_o)
    );

    function automatic bit f_cond(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            4'd1: return a == b;
            4'd2: return a != b;
            4'd3: return $signed(a) <= 0;
            4'd4: return $signed(a) > 0;
            4'd5, 4'd7: return $signed(a) < 0;
            4'd6, 4'd8: return $signed(a) >= 0;
            4'd9, 4'd10, 4'd11: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] f_tgt(input logic [3:0] op, input logic [31:0] pc,
                                          input logic [15:0] off, input logic [25:0] idx,
                                          input logic [31:0] jr);
        logic [31:0] s;
        s = pc + 32'd4;
        if (op == 4'd9 || op == 4'd10) return {s[31:28], idx, 2'b00};
        if (op == 4'd11) return jr;
        return s + ({{16{off[15]}}, off} * 32'd4);
    endfunction

    function automatic bit f_link(input logic [3:0] op);
        return op == 4'd7 || op == 4'd8 || op == 4'd10;
    endfunction

    function automatic string f_tag(input logic [3:0] op, input bit slot);
        if (slot) return "R9";
        case (op)
            4'd1, 4'd2: return "R3";
            4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8: return "R4";
            4'd9, 4'd10: return "R6";
            4'd11: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] op, input logic [31:0] pc, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] off, input logic [25:0] idx,
                        input logic [31:0] jr);
        bit          e_take;
        bit          e_link;
        logic [31:0] e_tgt;
        logic [31:0] e_npc;
        string       tag;
        @(negedge clk);
        op_i = op; pc_i = pc; rs_val_i = a; rt_val_i = b;
        offset_i = off; jidx_i = idx; jreg_i = jr;
        #1;
        e_take = f_cond(op, a, b) && !m_slot;
        e_link = f_link(op) && !m_slot;
        e_tgt  = f_tgt(op, pc, off, idx, jr);
        e_npc  = m_slot ? m_held : pc + 32'd4;
        tag    = f_tag(op, m_slot);
        chk(tag, "taken", 32'(taken_o), 32'(e_take));
        chk(m_slot ? "R9" : "R5", "npc", npc_o, e_npc);
        chk(m_slot ? "R9" : "R8", "link_we", 32'(link_we_o), 32'(e_link));
        if (e_link) begin
            chk("R8", "link_data", link_data_o, pc + 32'd4);
            chk("R8", "link_reg", 32'(link_reg_o), 32'd31);
        end
        @(posedge clk);
        if (m_slot) m_slot = 1'b0;
        else if (e_take) begin m_slot = 1'b1; m_held = e_tgt; end
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom_range(0, 5))
            0: return 32'd0;
            1: return 32'd1;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(posedge clk);
        @(negedge clk);
        pc_i = 32'h0000_1000;
        rst_n = 1'b1;
        #1;
        chk("R1", "npc after reset", npc_o, 32'h0000_1004);

        step(4'd0,  32'h100, 0, 0, 16'h0010, 0, 0);                    // R2 no-op
        step(4'd13, 32'h104, 5, 5, 16'h0010, 0, 0);                    // R2 unused code
        step(4'd1,  32'h200, 7, 7, 16'h0004, 0, 0);                    // R3 equal taken, R5
        step(4'd0,  32'h204, 0, 0, 0, 0, 0);                           // R9 slot
        step(4'd0,  32'h214, 0, 0, 0, 0, 0);                           // R10 resume
        step(4'd1,  32'h300, 7, 8, 16'h0004, 0, 0);                    // R3 equal not taken
        step(4'd2,  32'h304, 7, 8, 16'h8000, 0, 0);                    // R3 ne taken, R5 min offset
        step(4'd9,  32'h308, 0, 0, 0, 26'h3, 0);                       // R9 jump ignored in slot
        step(4'd3,  32'h400, 0, 0, 16'hFFFF, 0, 0);                    // R4 <=0 at zero
        step(4'd0,  32'h404, 0, 0, 0, 0, 0);
        step(4'd4,  32'h500, 0, 0, 16'h0001, 0, 0);                    // R4 >0 at zero not taken
        step(4'd5,  32'h504, 32'h8000_0000, 0, 16'h0001, 0, 0);        // R4 <0 most negative
        step(4'd10, 32'h508, 0, 0, 0, 26'h1, 0);                       // R9 link suppressed in slot
        step(4'd7,  32'h600, 5, 0, 16'h0002, 0, 0);                    // R8 link without taking
        step(4'd8,  32'h604, 5, 0, 16'h0002, 0, 0);                    // R8 link and taken
        step(4'd0,  32'h608, 0, 0, 0, 0, 0);
        step(4'd10, 32'hF000_0FFC, 0, 0, 0, 26'h3FF_FFFF, 0);          // R6 region from pc+4
        step(4'd0,  32'hF000_1000, 0, 0, 0, 0, 0);
        step(4'd11, 32'h700, 0, 0, 0, 0, 32'h1234_5677);               // R7 raw register address
        step(4'd0,  32'h704, 0, 0, 0, 0, 0);

        for (int i = 0; i < N_RANDOM; i++) begin
            logic [31:0] a;
            a = pick_val();
            step(4'($urandom_range(0, 15)), $urandom() & 32'hFFFF_FFFC, a,
                 ($urandom_range(0, 1) != 0) ? a : pick_val(),
                 16'($urandom()), 26'($urandom()), $urandom());
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule